// File: doc/BRIEF.md
# Double-Buffered 10-Bit PWM Generator

This block drives one pulse-width-modulated output. Its time base has 10 bits: an 8-bit period counter in the upper bits and two fine sub-count bits below it. A prescaler sits in front of the counter and divides by 1, 4 or 16. With division by 1, the fine bits are a free-running clock-phase pair. Otherwise, they are the top two bits of the prescaler. The counter climbs until it equals the period register. On the next counter step it returns to zero and a new period begins.

The duty value has 10 bits. Software writes it as a high byte and a separate 2-bit low field through a register-write port, and may do so at any moment. The written value waits in pending registers. Hardware copies it into an active latch only at the period boundary, so a period never sees a half-updated duty value. The output rises at the start of each period unless the active duty is zero. It falls once the 10-bit time base reaches the active duty.

Top module: `pwm_gen`

## Requirements
- R1: After the counter has equalled the period register `N`, the next counter step returns it to 0. One period lasts (N+1)·4·P input clocks, where P is the prescale value. `cntVal` shows the counter.
- R2: When the active duty value is nonzero, `pwmOut` is high in the first clock of each period. `pwmOut` is registered, so it follows the time base with one clock of delay.
- R3: An active duty value of 0 keeps `pwmOut` low for the whole period.
- R4: A write with `wrSel`=1 sets the pending duty high byte from `wrData[7:0]`. A write with `wrSel`=2 sets the pending low two bits from `wrData[1:0]`. For an active duty D within the period span, `pwmOut` is high for exactly D·P input clocks of each period.
- R5: A pending duty write made during a period does not change that period's output or `dutyHiAct`. The new value takes effect from the next period onward.
- R6: When D·P is at least the period length, `pwmOut` stays high for the entire period.
- R7: A write with `wrSel`=3 selects the prescale from `wrData[1:0]`: 00 divides by 1, 01 by 4, and 10 or 11 by 16.
- R8: A synchronous reset clears the counter, the sub-count, the prescaler and the active duty latch, and forces `pwmOut` low. The configuration registers keep their values and may be written while reset is held.
- R9: `dutyHiAct` shows the high byte of the active duty latch. It changes only when a period starts.
- R10: A write with `wrSel`=0 sets the period register from `wrData[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 period, 1 duty high, 2 duty low, 3 prescale |
| wrData | input | 8 | Write data |
| pwmOut | output | 1 | PWM output |
| cntVal | output | 8 | Current period counter |
| dutyHiAct | output | 8 | Active duty high byte |

## Verification
The assertions assume the following about the inputs:
- Reset is held from time zero.
- The period register and the prescale select change only while reset is held.

Under these conditions the counter can only step up by one or return to zero, and the active duty can only change together with a return to zero. The stimulus respects this:
- It writes all configuration during a reset pulse before each run.
- During a run it writes only the pending duty high byte.
- It never makes a pending write on the clock edge that ends a period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam logic [1:0] SEL_PERIOD = 2'd0;
  localparam logic [1:0] SEL_DUTY_HI = 2'd1;
  localparam logic [1:0] SEL_DUTY_LO = 2'd2;
  localparam logic [1:0] SEL_PSC = 2'd3;

  typedef struct packed {
    logic tick;
    logic wrap;
  } pwmStrobe_t;

  function automatic logic [2:0] pscShift(input logic [1:0] sel);
    case (sel)
      2'b00: pscShift = 3'd0;
      2'b01: pscShift = 3'd2;
      default: pscShift = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int FRAC_W = 2,
  parameter int PSC_LOG2_MAX = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        pscSel,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  period,
  output pwmStrobe_t        strb,
  output logic [FRAC_W-1:0] frac
);
  localparam int SUB_W = FRAC_W + PSC_LOG2_MAX;

  logic [SUB_W-1:0] sub;
  logic [SUB_W-1:0] subLast;
  logic [2:0] shift;

  always_comb begin
    shift = pscShift(pscSel);
    for (int i = 0; i < SUB_W; i++) begin
      subLast[i] = (i < FRAC_W + int'(shift));
    end
  end

  assign frac = FRAC_W'(sub >> shift);
  assign strb.tick = (sub == subLast);
  assign strb.wrap = strb.tick && (cnt == period);

  always_ff @(posedge clk) begin
    if (rst) sub <= '0;
    else if (strb.tick) sub <= '0;
    else sub <= sub + 1'b1;
  end
endmodule

// File: rtl/pwm_dp.sv
module pwm_dp
  import pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int FRAC_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [CNT_W-1:0]  wrData,
  input  pwmStrobe_t        strb,
  input  logic [FRAC_W-1:0] frac,
  output logic [CNT_W-1:0]  period,
  output logic [1:0]        pscSel,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  actHi,
  output logic              pwmOut
);
  localparam int TB_W = CNT_W + FRAC_W;

  logic [CNT_W-1:0]  pendHi;
  logic [FRAC_W-1:0] pendLo;
  logic [FRAC_W-1:0] actLo;
  logic [TB_W-1:0]   timeBase;
  logic [TB_W-1:0]   actDuty;

  always_ff @(posedge clk) begin
    if (wrEn) begin
      case (wrSel)
        SEL_PERIOD:  period <= wrData;
        SEL_DUTY_HI: pendHi <= wrData;
        SEL_DUTY_LO: pendLo <= wrData[FRAC_W-1:0];
        default:     pscSel <= wrData[1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (strb.wrap) cnt <= '0;
    else if (strb.tick) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      actHi <= '0;
      actLo <= '0;
    end else if (strb.wrap) begin
      actHi <= pendHi;
      actLo <= pendLo;
    end
  end

  assign timeBase = {cnt, frac};
  assign actDuty = {actHi, actLo};

  always_ff @(posedge clk) begin
    if (rst) pwmOut <= 1'b0;
    else pwmOut <= (timeBase < actDuty);
  end
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int FRAC_W = 2,
  parameter int PSC_LOG2_MAX = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  output logic             pwmOut,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] dutyHiAct
);
  pwmStrobe_t strb;
  logic [FRAC_W-1:0] frac;
  logic [CNT_W-1:0] period;
  logic [1:0] pscSel;

  pwm_ctrl #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .PSC_LOG2_MAX(PSC_LOG2_MAX)) u_ctrl (
    .clk(clk), .rst(rst), .pscSel(pscSel), .cnt(cntVal), .period(period),
    .strb(strb), .frac(frac)
  );

  pwm_dp #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .strb(strb), .frac(frac), .period(period), .pscSel(pscSel),
    .cnt(cntVal), .actHi(dutyHiAct), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             pwmOut,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] dutyHiAct
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!pwmOut && cntVal == '0 && dutyHiAct == '0)); // R8

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cntVal != $past(cntVal)) |-> (cntVal == '0 || cntVal == $past(cntVal) + 1'b1)); // R1

  AST_DUTY_AT_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(dutyHiAct) |-> (cntVal == '0)); // R9

  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(pwmOut) |-> (cntVal == '0)); // R2
endmodule

bind pwm_gen pwm_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .pwmOut(pwmOut), .cntVal(cntVal), .dutyHiAct(dutyHiAct)
);

// File: tb/tb_pwm_gen.sv
module tb_pwm_gen;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic pwmOut;
  logic [7:0] cntVal;
  logic [7:0] dutyHiAct;

  int checks = 0;
  int errors = 0;

  pwm_gen dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .pwmOut(pwmOut), .cntVal(cntVal), .dutyHiAct(dutyHiAct)
  );

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic wr(input int sel, input int data);
    wrEn = 1'b1;
    wrSel = 2'(sel);
    wrData = 8'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // R10 period write, R7 prescale write, R4 duty split into high byte and low field
  task automatic runCase(input int per, input int psc, input int duty, input int duty2Hi);
    int pre, span, k, act, pend, pi, newOut, actUsed;
    bit expOut, prevOut, wrote;
    string lbl;
    pre = (psc == 0) ? 1 : ((psc == 1) ? 4 : 16);
    span = (per + 1) * 4 * pre;
    rst = 1'b1;
    wr(0, per);
    wr(1, duty >> 2);
    wr(2, duty & 3);
    wr(3, psc);
    chk("R8 out", int'(pwmOut), 0);
    chk("R8 cnt", int'(cntVal), 0);
    chk("R8 duty", int'(dutyHiAct), 0);
    rst = 1'b0;
    k = 0; act = 0; pend = duty; pi = 0;
    expOut = 1'b0; prevOut = 1'b0; wrote = 1'b0;
    for (int c = 0; c < 3 * span; c++) begin
      wrEn = 1'b0;
      actUsed = act;
      newOut = (k < act * pre) ? 1 : 0;
      if (k == span - 1) begin
        k = 0; act = pend; pi++;
      end else begin
        k++;
      end
      if (pi == 1 && k == 2 && !wrote) begin
        // R5: write lands at the edge leaving k==1, never at a period end
        wrEn = 1'b1; wrSel = 2'd1; wrData = 8'(duty2Hi);
        pend = (duty2Hi << 2) | (pend & 3);
        wrote = 1'b1;
      end
      prevOut = expOut;
      expOut = (newOut != 0);
      @(negedge clk);
      chk(psc != 0 ? "R7 cnt" : "R1 cnt", int'(cntVal), k / (4 * pre));
      chk("R9 duty hi", int'(dutyHiAct), act >> 2);
      if (pi == 1 && wrote) lbl = "R5 out";
      else if (actUsed == 0) lbl = "R3 out";
      else if (actUsed * pre >= span) lbl = "R6 out";
      else if (expOut && !prevOut) lbl = "R2 out";
      else lbl = "R4 out";
      chk(lbl, int'(pwmOut), int'(expOut));
    end
    wrEn = 1'b0;
  endtask

  initial begin
    int pers[3];
    pers = '{0, 2, 5};
    repeat (2) @(negedge clk);
    for (int psc = 0; psc < 3; psc++) begin
      foreach (pers[p]) begin
        int stb;
        int duties[8];
        stb = (pers[p] + 1) * 4;
        duties = '{0, 1, 2, 5, stb - 1, stb, stb + 2, 1023};
        foreach (duties[d]) begin
          runCase(pers[p], psc, duties[d], (stb >> 1) >> 2);
        end
      end
    end
    // R7: select code 11 behaves as divide by 16
    runCase(1, 3, 13, 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule